// File: doc/BRIEF.md
# Prioritised UART Interrupt Identifier

This block merges the four interrupt causes of a serial port into one interrupt line and a small identification code. The four causes are a receive-side error condition, received data waiting, an empty transmit holding register, and a change on the modem handshake inputs. A 4-bit mask enables each cause separately. When more than one enabled cause is active, only the most urgent is reported. The identification code is what software reads to learn why it was interrupted.

The receive, error and modem causes are level inputs. The logic that produces each of them also clears it. The transmit-empty cause is kept inside the block. It becomes pending when the holding register goes from full to empty. It also becomes pending when its enable bit is turned on while the register is already empty. A read of the identification code that reports transmit-empty clears it. Software pulses the read strobe for one cycle in the cycle it samples the code. Both outputs are registered, so each one reflects the inputs and state of the previous clock edge.

Top module: `uart_irq_id`

## Requirements
- R1: While reset is high, and on the first sample after it, `irq_o` is 0 and `id_o` is 3'b001.
- R2: When no enabled cause is pending, `id_o` is 3'b001: bit 0 is 1 and bits 2:1 are 00.
- R3: `irq_o` always equals the inverse of `id_o[0]`, so it is 1 exactly when an enabled cause is pending.
- R4: An enabled receive-error cause (`line_err_i` with `irq_en_i[2]`) has the highest priority and gives `id_o` = 3'b110.
- R5: Received data (`rx_ready_i` with `irq_en_i[0]`), when no enabled receive error is present, gives `id_o` = 3'b100. It takes priority over transmit-empty and modem change.
- R6: A pending transmit-empty cause (`irq_en_i[1]`), when no higher cause is active, gives `id_o` = 3'b010. It takes priority over modem change.
- R7: Modem change (`modem_chg_i` with `irq_en_i[3]`) alone gives `id_o` = 3'b000.
- R8: A cause whose enable bit is 0 never appears in `id_o`. The bit positions are: 0 received data, 1 transmit-empty, 2 receive error, 3 modem change.
- R9: Transmit-empty becomes pending when `thr_empty_i` rises. It is dropped at once while `thr_empty_i` is 0.
- R10: If `id_rd_i` is high in a cycle where `id_o` is 3'b010, transmit-empty is cleared from the next sample on. It stays cleared while the register remains empty.
- R11: A read while `id_o` shows any other code leaves a pending transmit-empty untouched.
- R12: Transmit-empty becomes pending again when `irq_en_i[1]` goes from 0 to 1 while `thr_empty_i` is 1.
- R13: A change on any input shows on the outputs after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_err_i | input | 1 | Receive error condition (level) |
| rx_ready_i | input | 1 | Received data waiting (level) |
| thr_empty_i | input | 1 | Transmit holding register is empty (level) |
| modem_chg_i | input | 1 | Modem input change seen (level) |
| irq_en_i | input | 4 | Per-cause enable mask |
| id_rd_i | input | 1 | One-cycle strobe: identification code is being read |
| irq_o | output | 1 | Interrupt request, registered |
| id_o | output | 3 | Identification code, registered |

## Verification
The checker tests three things on every cycle. First, it checks that the interrupt line is the inverse of the no-pending bit. Second, it checks that an enabled receive error or enabled received data produces its code one edge later. Third, it checks that with nothing enabled and active the idle code appears. It also checks that a read of the transmit-empty code removes that code, and that a full holding register never reports it. The bench scenarios cover the behaviour that depends on history. These include re-arming when the register becomes empty or the enable bit rises, and a read of another code leaving transmit-empty pending. They also cover the priority order across mixed patterns and the exact one-edge latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned SRC_N  = 4;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned ID_W   = CODE_W + 1;

  // positions of the causes within the enable mask
  localparam int unsigned EN_RX    = 0;
  localparam int unsigned EN_THR   = 1;
  localparam int unsigned EN_LINE  = 2;
  localparam int unsigned EN_MODEM = 3;

  typedef enum logic [CODE_W-1:0] {
    CODE_MODEM = 2'b00,
    CODE_THR   = 2'b01,
    CODE_RX    = 2'b10,
    CODE_LINE  = 2'b11
  } irq_code_e;

  // code reported for the cause at a given mask position
  function automatic irq_code_e code_of(input int idx);
    case (idx)
      EN_RX:   code_of = CODE_RX;
      EN_THR:  code_of = CODE_THR;
      EN_LINE: code_of = CODE_LINE;
      default: code_of = CODE_MODEM;
    endcase
  endfunction

  // urgency of the cause at a given mask position, larger wins
  function automatic int rank_of(input int idx);
    case (idx)
      EN_LINE: rank_of = 3;
      EN_RX:   rank_of = 2;
      EN_THR:  rank_of = 1;
      default: rank_of = 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
  import uart_irq_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_N,
  parameter int unsigned CW    = CODE_W
) (
  input  logic [N_SRC-1:0] active_i,
  output logic             any_o,
  output logic [CW-1:0]    code_o
);

  // walk ranks upward, so the last match is the most urgent active cause
  always_comb begin
    any_o  = |active_i;
    code_o = '0;
    for (int r = 0; r < int'(N_SRC); r++) begin
      for (int s = 0; s < int'(N_SRC); s++) begin
        if (active_i[s] && rank_of(s) == r) begin
          code_o = CW'(code_of(s));
        end
      end
    end
  end

endmodule

// File: rtl/uart_irq_thr_track.sv
module uart_irq_thr_track (
  input  logic clk,
  input  logic rst,
  input  logic empty_i,
  input  logic en_i,
  input  logic clr_i,
  output logic pend_next_o
);

  logic empty_q;
  logic en_q;
  logic pend_q;
  logic arm;

  // the register just became empty, or its enable was switched on while empty
  assign arm = (empty_i && !empty_q) || (empty_i && en_i && !en_q);

  always_comb begin
    if (!empty_i) begin
      pend_next_o = 1'b0;
    end else if (arm) begin
      pend_next_o = 1'b1;
    end else if (clr_i) begin
      pend_next_o = 1'b0;
    end else begin
      pend_next_o = pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_q <= 1'b1;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_i;
      en_q    <= en_i;
      pend_q  <= pend_next_o;
    end
  end

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             line_err_i,
  input  logic             rx_ready_i,
  input  logic             thr_empty_i,
  input  logic             modem_chg_i,
  input  logic [SRC_N-1:0] irq_en_i,
  input  logic             id_rd_i,
  output logic             irq_o,
  output logic [ID_W-1:0]  id_o
);

  logic              thr_pend;
  logic              thr_clr;
  logic [SRC_N-1:0]  raw_src;
  logic [SRC_N-1:0]  active;
  logic              any_pend;
  logic [CODE_W-1:0] win_code;
  logic              irq_q;
  logic [ID_W-1:0]   id_q;

  // a read that returns the transmit-empty code acknowledges it
  assign thr_clr = id_rd_i && !id_q[0] && (id_q[ID_W-1:1] == CODE_THR);

  uart_irq_thr_track u_thr (
    .clk         (clk),
    .rst         (rst),
    .empty_i     (thr_empty_i),
    .en_i        (irq_en_i[EN_THR]),
    .clr_i       (thr_clr),
    .pend_next_o (thr_pend)
  );

  always_comb begin
    raw_src            = '0;
    raw_src[EN_RX]     = rx_ready_i;
    raw_src[EN_THR]    = thr_pend;
    raw_src[EN_LINE]   = line_err_i;
    raw_src[EN_MODEM]  = modem_chg_i;
  end

  assign active = raw_src & irq_en_i;

  uart_irq_arb #(
    .N_SRC (SRC_N),
    .CW    (CODE_W)
  ) u_arb (
    .active_i (active),
    .any_o    (any_pend),
    .code_o   (win_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      id_q  <= ID_W'(1);
    end else begin
      irq_q <= any_pend;
      id_q  <= {(any_pend ? win_code : CODE_W'(0)), !any_pend};
    end
  end

  assign irq_o = irq_q;
  assign id_o  = id_q;

endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk
  import uart_irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             line_err_i,
  input logic             rx_ready_i,
  input logic             thr_empty_i,
  input logic             modem_chg_i,
  input logic [SRC_N-1:0] irq_en_i,
  input logic             id_rd_i,
  input logic             irq_o,
  input logic [ID_W-1:0]  id_o
);

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (rst)
    irq_o == !id_o[0]); // R3

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
    (line_err_i && irq_en_i[EN_LINE]) |=> (id_o == 3'b110)); // R4

  AST_RX_SECOND: assert property (@(posedge clk) disable iff (rst)
    (rx_ready_i && irq_en_i[EN_RX] && !(line_err_i && irq_en_i[EN_LINE]))
      |=> (id_o == 3'b100)); // R5

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    (!(line_err_i && irq_en_i[EN_LINE]) && !(rx_ready_i && irq_en_i[EN_RX]) &&
     !(modem_chg_i && irq_en_i[EN_MODEM]) && !irq_en_i[EN_THR])
      |=> (id_o == 3'b001)); // R2

  AST_FULL_NO_THR: assert property (@(posedge clk) disable iff (rst)
    !thr_empty_i |=> (id_o != 3'b010)); // R9

  AST_READ_ACKS_THR: assert property (@(posedge clk) disable iff (rst)
    (id_rd_i && id_o == 3'b010) |=> (id_o != 3'b010)); // R10

endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_err_i  (line_err_i),
  .rx_ready_i  (rx_ready_i),
  .thr_empty_i (thr_empty_i),
  .modem_chg_i (modem_chg_i),
  .irq_en_i    (irq_en_i),
  .id_rd_i     (id_rd_i),
  .irq_o       (irq_o),
  .id_o        (id_o)
);

// File: tb/uart_irq_id_tb.sv
`timescale 1ns/1ps
module uart_irq_id_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_err_i = 1'b0;
  logic       rx_ready_i = 1'b0;
  logic       thr_empty_i = 1'b1;
  logic       modem_chg_i = 1'b0;
  logic [3:0] irq_en_i = 4'b0000;
  logic       id_rd_i = 1'b0;
  logic       irq_o;
  logic [2:0] id_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_irq_id u_dut (
    .clk         (clk),
    .rst         (rst),
    .line_err_i  (line_err_i),
    .rx_ready_i  (rx_ready_i),
    .thr_empty_i (thr_empty_i),
    .modem_chg_i (modem_chg_i),
    .irq_en_i    (irq_en_i),
    .id_rd_i     (id_rd_i),
    .irq_o       (irq_o),
    .id_o        (id_o)
  );

  // vector: {line, rx, thr_empty, modem} , enable[3:0] , read , expected id
  localparam int NV = 20;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0010, 4'b0000, 1'b0, 3'b001}, //  0 R2 nothing enabled
    {4'b0010, 4'b0010, 1'b0, 3'b010}, //  1 R12 enable rise while empty
    {4'b0011, 4'b1010, 1'b0, 3'b010}, //  2 R6 thr over modem
    {4'b0111, 4'b1011, 1'b0, 3'b100}, //  3 R5 rx over thr
    {4'b1111, 4'b1111, 1'b0, 3'b110}, //  4 R4 line over all
    {4'b1111, 4'b1111, 1'b1, 3'b110}, //  5 R11 read of line code
    {4'b0011, 4'b1010, 1'b0, 3'b010}, //  6 R11 thr still pending
    {4'b0011, 4'b1010, 1'b1, 3'b000}, //  7 R10 R7 read acks thr
    {4'b0010, 4'b1010, 1'b0, 3'b001}, //  8 R10 stays cleared
    {4'b0000, 4'b1010, 1'b0, 3'b001}, //  9 R9 register full
    {4'b0010, 4'b1010, 1'b0, 3'b010}, // 10 R9 empty again
    {4'b1111, 4'b0000, 1'b0, 3'b001}, // 11 R8 all masked
    {4'b0010, 4'b0010, 1'b0, 3'b010}, // 12 R12 re-enabled
    {4'b0010, 4'b0010, 1'b1, 3'b001}, // 13 R10 read acks
    {4'b0010, 4'b0000, 1'b0, 3'b001}, // 14 R8 disabled
    {4'b0010, 4'b0010, 1'b0, 3'b010}, // 15 R12 rise re-arms
    {4'b0100, 4'b0001, 1'b0, 3'b100}, // 16 R8 rx bit 0
    {4'b0001, 4'b1000, 1'b0, 3'b000}, // 17 R7 modem bit 3
    {4'b1000, 4'b0100, 1'b0, 3'b110}, // 18 R4 line bit 2
    {4'b1000, 4'b1011, 1'b0, 3'b001}  // 19 R8 line masked
  };

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [11:0] v);
    {line_err_i, rx_ready_i, thr_empty_i, modem_chg_i} = v[11:8];
    irq_en_i = v[7:4];
    id_rd_i  = v[3];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {irq_o, id_o}, 4'b0001);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {irq_o, id_o}, 4'b0001);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check($sformatf("vector %0d id", i), {1'b0, id_o}, {1'b0, VEC[i][2:0]});
      check($sformatf("vector %0d R3 irq", i), {3'b000, irq_o}, {3'b000, !VEC[i][0]});
    end

    // R13: a new input is not visible before the edge, and is visible after one edge
    apply({4'b0000, 4'b0000, 1'b0, 3'b001});
    @(negedge clk);
    line_err_i = 1'b1;
    irq_en_i   = 4'b0100;
    #1;
    check("R13 before edge", {irq_o, id_o}, 4'b0001);
    @(negedge clk);
    check("R13 after one edge", {irq_o, id_o}, 4'b1110);

    // R1: reset while a cause is pending
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset with cause pending", {irq_o, id_o}, 4'b0001);
    rst = 1'b0;
    line_err_i = 1'b0;
    irq_en_i   = 4'b0000;
    @(negedge clk);
    check("R1 released", {irq_o, id_o}, 4'b0001);

    // R12: no re-arm when enable rises while the register is full
    thr_empty_i = 1'b0;
    @(negedge clk);
    irq_en_i = 4'b0010;
    @(negedge clk);
    check("R12 rise while full", {irq_o, id_o}, 4'b0001);
    thr_empty_i = 1'b1;
    @(negedge clk);
    check("R9 empty after full", {irq_o, id_o}, 4'b1010);

    finish_run();
  end

endmodule